// File: doc/BRIEF.md
# I2C-over-AUX Transaction Mapper

This block sits between a decoded AUX request path and a byte-level I2C master. Each incoming request names a kind (write, read or write-status), a middle-of-transaction flag (MOT), an address-only flag, a 7-bit device address, a byte count and, for writes, data taken from a small buffer the requester owns. The mapper turns each request into a short list of primitive bus commands (START, address byte, WRITE byte, READ byte, STOP). It issues one command at a time and waits for the I2C master's response before it issues the next.

The mapper keeps the I2C bus state between requests: idle, open for writing or open for reading, together with the device last addressed. A data request to the same device in the same direction as the open bus goes straight to the data bytes. Any other data request opens with a START, which is a repeated START when the bus is already open. A cleared MOT closes the bus with a STOP. When a request finishes, the mapper reports how many bytes were acknowledged and whether a NACK cut it short. It also holds the number of write bytes left over from a partially acknowledged write, so that a later write-status request can report that number.

Top module: `aux_i2c_mapper`

## Requirements
- R1: After reset `req_ready` is 1, `cmd_valid` and `done` are 0, the bus is idle, and the first data request opens with START.
- R2: Command codes on `cmd_op` are START=1, ADDR=2, WRITE=3, READ=4 and STOP=5. An address-only request with MOT=1 issues START and then ADDR with byte {dev, dir}, where dir is 1 for a read. It leaves the bus open in that direction and reports a count of 0.
- R3: An address-only request with MOT=0 issues only STOP. After any STOP the bus is idle and no device address is remembered, so the next data request opens with START.
- R4: `req_kind` 2'b00 is a write and 2'b01 is a read. A data request carries N = `req_len`+1 bytes. When the bus is idle, or the device or the direction differs from the open bus, the mapper issues START, then ADDR, then N byte commands. WRITE number i carries the buffer byte at `wbuf_idx`=i. The bytes returned for the READ commands appear in order on `rd_valid`/`rd_byte`.
- R5: A data request to the device of the open bus, in the same direction, issues only its N byte commands.
- R6: A data request with MOT=0 ends with a STOP after its last byte. The byte of a READ command is 1 (master NACK) only on the final byte of a request that closes with STOP, and is 0 otherwise.
- R7: A NACK on ADDR ends the request with a STOP. It reports `done_nack`=1 and a count of 0, and leaves the bus idle.
- R8: A NACK on WRITE byte k (counting from 0) issues STOP at once and sends no further bytes. It reports `done_nack`=1, count k and `done_left` N-k.
- R9: `req_kind` 2'b1x is a write-status request. With MOT=1 it issues no command, leaves the bus state unchanged, and reports in `done_left` the remaining count held from the last write.
- R10: A write-status request with MOT=0 issues only STOP, which leaves the bus idle, and reports the held remaining count.
- R11: A command on `cmd_op`/`cmd_byte` stays unchanged until `cmd_ready` accepts it, and the next command does not appear until the response to it has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Mapper is free to take a request |
| req_kind | input | 2 | 00 write, 01 read, 1x write-status |
| req_mot | input | 1 | 1 keeps the bus open after the request |
| req_addr_only | input | 1 | Request has no data phase |
| req_dev | input | DEV_W | 7-bit I2C device address |
| req_len | input | LEN_W | Byte count minus one |
| wbuf_idx | output | LEN_W | Index of the write byte wanted |
| wbuf_byte | input | DATA_W | Write byte at `wbuf_idx` |
| cmd_valid | output | 1 | Command offered to the I2C master |
| cmd_ready | input | 1 | I2C master accepts the command |
| cmd_op | output | 3 | Command code |
| cmd_byte | output | DATA_W | Address, write data, or the NACK flag of a read |
| rsp_valid | input | 1 | Response to the accepted command |
| rsp_ack | input | 1 | Slave acknowledged the address or write byte |
| rsp_byte | input | DATA_W | Byte read from the slave |
| rd_valid | output | 1 | Read byte available |
| rd_byte | output | DATA_W | Read byte |
| done | output | 1 | One-cycle pulse at the end of a request |
| done_nack | output | 1 | The request was cut short by a NACK |
| done_count | output | LEN_W+1 | Bytes acknowledged or read |
| done_left | output | LEN_W+1 | Held remaining count of the last write |

## Verification
Two rules can fall on the same byte. One is the early end of a write after a data NACK, and the other is the closing STOP requested by MOT=0. The bench provokes this with a two-byte MOT=0 write whose final byte is NACKed. It judges the result by requiring exactly one STOP after that byte, a count of 1, a remaining count of 1, and a following write-status request that reads back the same remaining count. A separate case holds `cmd_ready` low for several cycles and confirms that the pending command does not change.

// File: rtl/aux_i2c_pkg.sv
package aux_i2c_pkg;

   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_START = 3'd1,
      OP_ADDR  = 3'd2,
      OP_WRITE = 3'd3,
      OP_READ  = 3'd4,
      OP_STOP  = 3'd5
   } op_e;

   typedef enum logic [1:0] {
      BUS_IDLE = 2'd0,
      BUS_WR   = 2'd1,
      BUS_RD   = 2'd2
   } bus_e;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_CMD  = 2'd1,
      S_RSP  = 2'd2,
      S_DONE = 2'd3
   } seq_e;

   // what one request needs: an opening phase, a data phase, a closing STOP
   typedef struct packed {
      logic start;
      logic data;
      logic stop;
   } plan_t;

endpackage

// File: rtl/aux_i2c_plan.sv
module aux_i2c_plan
   import aux_i2c_pkg::*;
#(
   parameter int DEV_W = 7
) (
   input  logic [1:0]       kind,
   input  logic             mot,
   input  logic             addr_only,
   input  logic [DEV_W-1:0] dev,
   input  bus_e             bus_st,
   input  logic [DEV_W-1:0] bus_dev,
   output plan_t            pl
);

   logic is_stat;
   logic is_rd;
   logic same_path;

   assign is_stat   = kind[1];
   assign is_rd     = kind[0];
   assign same_path = (bus_st == (is_rd ? BUS_RD : BUS_WR)) && (bus_dev == dev);

   always_comb begin
      pl = '0;
      if (is_stat) begin
         pl.stop = ~mot;
      end else if (addr_only) begin
         pl.start = mot;
         pl.stop  = ~mot;
      end else begin
         pl.start = ~same_path;
         pl.data  = 1'b1;
         pl.stop  = ~mot;
      end
   end

endmodule

// File: rtl/aux_i2c_bus.sv
module aux_i2c_bus
   import aux_i2c_pkg::*;
#(
   parameter int DEV_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_open,
   input  logic             ev_stop,
   input  logic             open_rd,
   input  logic [DEV_W-1:0] open_dev,
   output bus_e             bus_st,
   output logic [DEV_W-1:0] bus_dev
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_st  <= BUS_IDLE;
         bus_dev <= '0;
      end else if (ev_stop) begin
         bus_st  <= BUS_IDLE;
         bus_dev <= '0;
      end else if (ev_open) begin
         bus_st  <= open_rd ? BUS_RD : BUS_WR;
         bus_dev <= open_dev;
      end
   end

   AST_STOP_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |=> (bus_st == BUS_IDLE && bus_dev == '0)); // R3

   AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_open && ev_stop)); // R2

endmodule

// File: rtl/aux_i2c_seq.sv
module aux_i2c_seq
   import aux_i2c_pkg::*;
#(
   parameter int DEV_W          = 7,
   parameter int LEN_W          = 4,
   parameter int DATA_W         = 8,
   parameter bit READ_LAST_NACK = 1'b1,
   localparam int CNT_W         = LEN_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [LEN_W-1:0]  req_len,
   input  plan_t             pl,
   output logic [LEN_W-1:0]  wbuf_idx,
   input  logic [DATA_W-1:0] wbuf_byte,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [2:0]        cmd_op,
   output logic [DATA_W-1:0] cmd_byte,
   input  logic              rsp_valid,
   input  logic              rsp_ack,
   input  logic [DATA_W-1:0] rsp_byte,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_byte,
   output logic              done,
   output logic              done_nack,
   output logic [CNT_W-1:0]  done_count,
   output logic [CNT_W-1:0]  done_left,
   output logic              ev_open,
   output logic              ev_stop,
   output logic              open_rd,
   output logic [DEV_W-1:0]  open_dev
);

   seq_e             st_q;
   op_e              op_q;
   plan_t            pl_q;
   logic [DEV_W-1:0] dev_q;
   logic [CNT_W-1:0] idx_q;
   logic [CNT_W-1:0] last_q;
   logic [CNT_W-1:0] acks_q;
   logic [CNT_W-1:0] left_q;
   logic             rd_q;
   logic             stat_q;
   logic             wdata_q;
   logic             nack_q;
   logic             stopped_q;
   logic             issued_q;
   logic             rd_nack;
   logic             at_last;

   assign at_last = (idx_q == last_q);

   generate
      if (READ_LAST_NACK) begin : g_rd_nack
         assign rd_nack = at_last && pl_q.stop;
      end else begin : g_rd_ack
         assign rd_nack = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         op_q      <= OP_NONE;
         pl_q      <= '0;
         dev_q     <= '0;
         idx_q     <= '0;
         last_q    <= '0;
         acks_q    <= '0;
         left_q    <= '0;
         rd_q      <= 1'b0;
         stat_q    <= 1'b0;
         wdata_q   <= 1'b0;
         nack_q    <= 1'b0;
         stopped_q <= 1'b0;
         issued_q  <= 1'b0;
      end else begin
         unique case (st_q)
            S_IDLE: if (req_valid) begin
               pl_q      <= pl;
               dev_q     <= req_dev;
               rd_q      <= req_kind[0];
               stat_q    <= req_kind[1];
               wdata_q   <= ~req_kind[1] & ~req_kind[0] & pl.data;
               last_q    <= {1'b0, req_len};
               idx_q     <= '0;
               acks_q    <= '0;
               nack_q    <= 1'b0;
               stopped_q <= 1'b0;
               issued_q  <= 1'b0;
               if (pl.start) begin
                  op_q <= OP_START;
                  st_q <= S_CMD;
               end else if (pl.data) begin
                  op_q <= req_kind[0] ? OP_READ : OP_WRITE;
                  st_q <= S_CMD;
               end else if (pl.stop) begin
                  op_q <= OP_STOP;
                  st_q <= S_CMD;
               end else begin
                  st_q <= S_DONE;
               end
            end
            S_CMD: if (cmd_ready) begin
               st_q     <= S_RSP;
               issued_q <= 1'b1;
            end
            S_RSP: if (rsp_valid) begin
               st_q <= S_CMD;
               unique case (op_q)
                  OP_START: op_q <= OP_ADDR;
                  OP_ADDR: begin
                     if (!rsp_ack) begin
                        nack_q <= 1'b1;
                        op_q   <= OP_STOP;
                        if (wdata_q) left_q <= last_q + CNT_W'(1);
                     end else if (pl_q.data) begin
                        op_q <= rd_q ? OP_READ : OP_WRITE;
                     end else begin
                        st_q <= S_DONE;
                     end
                  end
                  OP_WRITE, OP_READ: begin
                     if (op_q == OP_WRITE && !rsp_ack) begin
                        nack_q <= 1'b1;
                        op_q   <= OP_STOP;
                        left_q <= last_q + CNT_W'(1) - idx_q;
                     end else begin
                        acks_q <= acks_q + CNT_W'(1);
                        idx_q  <= idx_q + CNT_W'(1);
                        if (at_last) begin
                           if (op_q == OP_WRITE) left_q <= '0;
                           if (pl_q.stop) op_q <= OP_STOP;
                           else           st_q <= S_DONE;
                        end
                     end
                  end
                  OP_STOP: begin
                     stopped_q <= 1'b1;
                     st_q      <= S_DONE;
                  end
                  default: st_q <= S_DONE;
               endcase
            end
            S_DONE: st_q <= S_IDLE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (op_q)
         OP_ADDR:  cmd_byte = {dev_q, rd_q};
         OP_WRITE: cmd_byte = wbuf_byte;
         OP_READ:  cmd_byte = {{(DATA_W-1){1'b0}}, rd_nack};
         default:  cmd_byte = '0;
      endcase
   end

   assign req_ready  = (st_q == S_IDLE);
   assign cmd_valid  = (st_q == S_CMD);
   assign cmd_op     = op_q;
   assign wbuf_idx   = idx_q[LEN_W-1:0];
   assign rd_valid   = (st_q == S_RSP) && rsp_valid && (op_q == OP_READ);
   assign rd_byte    = rsp_byte;
   assign done       = (st_q == S_DONE);
   assign done_nack  = nack_q;
   assign done_count = acks_q;
   assign done_left  = left_q;
   assign ev_stop    = done && stopped_q;
   assign ev_open    = done && issued_q && !stopped_q;
   assign open_rd    = rd_q;
   assign open_dev   = dev_q;

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte))); // R11

   AST_ADDR_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_RSP && op_q == OP_ADDR && rsp_valid && !rsp_ack)
         |=> (cmd_valid && cmd_op == OP_STOP)); // R7

   AST_STAT_ONLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && stat_q) |-> (cmd_op == OP_STOP)); // R10

   AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (acks_q <= last_q + CNT_W'(1))); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R1

endmodule

// File: rtl/aux_i2c_mapper.sv
module aux_i2c_mapper
   import aux_i2c_pkg::*;
#(
   parameter int DEV_W          = 7,
   parameter int LEN_W          = 4,
   parameter int DATA_W         = 8,
   parameter bit READ_LAST_NACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic              req_mot,
   input  logic              req_addr_only,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [LEN_W-1:0]  req_len,
   output logic [LEN_W-1:0]  wbuf_idx,
   input  logic [DATA_W-1:0] wbuf_byte,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [2:0]        cmd_op,
   output logic [DATA_W-1:0] cmd_byte,
   input  logic              rsp_valid,
   input  logic              rsp_ack,
   input  logic [DATA_W-1:0] rsp_byte,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_byte,
   output logic              done,
   output logic              done_nack,
   output logic [LEN_W:0]    done_count,
   output logic [LEN_W:0]    done_left
);

   if (DATA_W != DEV_W + 1) begin : g_bad_width
      $error("aux_i2c_mapper: DATA_W must equal DEV_W + 1");
   end
   if (LEN_W < 1 || LEN_W > 8) begin : g_bad_len
      $error("aux_i2c_mapper: LEN_W must lie in 1..8");
   end

   plan_t            pl;
   bus_e             bus_st;
   logic [DEV_W-1:0] bus_dev;
   logic             ev_open;
   logic             ev_stop;
   logic             open_rd;
   logic [DEV_W-1:0] open_dev;

   aux_i2c_plan #(.DEV_W(DEV_W)) i_plan (
      .kind      (req_kind),
      .mot       (req_mot),
      .addr_only (req_addr_only),
      .dev       (req_dev),
      .bus_st    (bus_st),
      .bus_dev   (bus_dev),
      .pl        (pl)
   );

   aux_i2c_bus #(.DEV_W(DEV_W)) i_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_open  (ev_open),
      .ev_stop  (ev_stop),
      .open_rd  (open_rd),
      .open_dev (open_dev),
      .bus_st   (bus_st),
      .bus_dev  (bus_dev)
   );

   aux_i2c_seq #(
      .DEV_W          (DEV_W),
      .LEN_W          (LEN_W),
      .DATA_W         (DATA_W),
      .READ_LAST_NACK (READ_LAST_NACK)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_kind   (req_kind),
      .req_dev    (req_dev),
      .req_len    (req_len),
      .pl         (pl),
      .wbuf_idx   (wbuf_idx),
      .wbuf_byte  (wbuf_byte),
      .cmd_valid  (cmd_valid),
      .cmd_ready  (cmd_ready),
      .cmd_op     (cmd_op),
      .cmd_byte   (cmd_byte),
      .rsp_valid  (rsp_valid),
      .rsp_ack    (rsp_ack),
      .rsp_byte   (rsp_byte),
      .rd_valid   (rd_valid),
      .rd_byte    (rd_byte),
      .done       (done),
      .done_nack  (done_nack),
      .done_count (done_count),
      .done_left  (done_left),
      .ev_open    (ev_open),
      .ev_stop    (ev_stop),
      .open_rd    (open_rd),
      .open_dev   (open_dev)
   );

endmodule

// File: tb/test_aux_i2c_mapper.sv
`timescale 1ns/1ps
module test_aux_i2c_mapper;

   localparam int C_START = 1;
   localparam int C_ADDR  = 2;
   localparam int C_WRITE = 3;
   localparam int C_READ  = 4;
   localparam int C_STOP  = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [1:0] req_kind = '0;
   logic       req_mot = 1'b0;
   logic       req_addr_only = 1'b0;
   logic [6:0] req_dev = '0;
   logic [3:0] req_len = '0;
   logic [3:0] wbuf_idx;
   logic [7:0] wbuf_byte;
   logic       cmd_valid;
   logic       cmd_ready = 1'b0;
   logic [2:0] cmd_op;
   logic [7:0] cmd_byte;
   logic       rsp_valid = 1'b0;
   logic       rsp_ack = 1'b1;
   logic [7:0] rsp_byte = '0;
   logic       rd_valid;
   logic [7:0] rd_byte;
   logic       done;
   logic       done_nack;
   logic [4:0] done_count;
   logic [4:0] done_left;

   logic [7:0]  wb [16];
   logic [10:0] got [32];
   logic [10:0] exq [32];
   logic [7:0]  rdg [16];
   int          got_n, exp_n, rd_n;
   logic        d_nack;
   int          d_cnt, d_left;
   int          checks = 0;
   int          errors = 0;

   always #5 clk = ~clk;

   assign wbuf_byte = wb[wbuf_idx];

   aux_i2c_mapper i_aux_i2c_mapper (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_mot(req_mot), .req_addr_only(req_addr_only),
      .req_dev(req_dev), .req_len(req_len), .wbuf_idx(wbuf_idx), .wbuf_byte(wbuf_byte),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
      .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_byte(rsp_byte),
      .rd_valid(rd_valid), .rd_byte(rd_byte), .done(done), .done_nack(done_nack),
      .done_count(done_count), .done_left(done_left)
   );

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   task automatic ex_clr();
      exp_n = 0;
   endtask

   task automatic ex(input int op, input int b);
      exq[exp_n] = {op[2:0], b[7:0]};
      exp_n++;
   endtask

   // one request; the responder NACKs the command with index nack_at
   task automatic run(input logic [1:0] kind, input logic mot, input logic ao,
                      input logic [6:0] dev, input logic [3:0] len,
                      input int nack_at, input int hold);
      bit fin = 0;
      got_n = 0;
      rd_n  = 0;
      @(negedge clk);
      req_kind = kind; req_mot = mot; req_addr_only = ao;
      req_dev = dev; req_len = len; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
         if (done) begin
            d_nack = done_nack;
            d_cnt  = int'(done_count);
            d_left = int'(done_left);
            fin = 1;
         end else if (cmd_valid) begin
            logic [2:0] op0;
            logic [7:0] b0;
            op0 = cmd_op;
            b0  = cmd_byte;
            for (int h = 0; h < hold; h++) begin
               @(negedge clk);
               chk(cmd_valid && cmd_op == op0 && cmd_byte == b0, "R11",
                   "command held while not accepted", int'(cmd_op), int'(op0));
            end
            cmd_ready = 1'b1;
            @(negedge clk);
            cmd_ready = 1'b0;
            rsp_valid = 1'b1;
            rsp_ack   = (got_n != nack_at);
            rsp_byte  = 8'h60 + 8'(got_n);
            #1;
            if (rd_valid) begin
               rdg[rd_n] = rd_byte;
               rd_n++;
            end
            got[got_n] = {op0, b0};
            got_n++;
            @(negedge clk);
            rsp_valid = 1'b0;
            rsp_ack   = 1'b1;
         end else begin
            @(negedge clk);
         end
      end
      if (!fin) chk(0, "R11", "request never finished", 0, 1);
   endtask

   task automatic cmp(input string tag);
      chk(got_n == exp_n, tag, "command count", got_n, exp_n);
      if (got_n == exp_n)
         for (int i = 0; i < exp_n; i++)
            chk(got[i] == exq[i], tag, $sformatf("command %0d op_byte", i),
                int'(got[i]), int'(exq[i]));
   endtask

   task automatic chk_done(input string tag, input bit nk, input int cnt, input int left);
      chk(d_nack == nk, tag, "done_nack", int'(d_nack), int'(nk));
      chk(d_cnt == cnt, tag, "done_count", d_cnt, cnt);
      chk(d_left == left, tag, "done_left", d_left, left);
   endtask

   task automatic t_reset();
      chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
      chk(cmd_valid == 1'b0, "R1", "cmd_valid after reset", int'(cmd_valid), 0);
      chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
   endtask

   task automatic t_addr_open();
      run(2'b00, 1, 1, 7'h50, 0, -1, 0);
      ex_clr(); ex(C_START, 0); ex(C_ADDR, 8'hA0);
      cmp("R2");
      chk(d_cnt == 0, "R2", "address-only count", d_cnt, 0);
   endtask

   task automatic t_same_write();
      run(2'b00, 1, 0, 7'h50, 2, -1, 3);
      ex_clr(); ex(C_WRITE, 8'h11); ex(C_WRITE, 8'h22); ex(C_WRITE, 8'h33);
      cmp("R5");
      chk_done("R5", 0, 3, 0);
   endtask

   task automatic t_write_close();
      run(2'b00, 0, 0, 7'h50, 0, -1, 0);
      ex_clr(); ex(C_WRITE, 8'h11); ex(C_STOP, 0);
      cmp("R6");
      run(2'b00, 1, 0, 7'h50, 1, -1, 0);
      ex_clr(); ex(C_START, 0); ex(C_ADDR, 8'hA0); ex(C_WRITE, 8'h11); ex(C_WRITE, 8'h22);
      cmp("R3");
   endtask

   task automatic t_read_new();
      run(2'b01, 0, 0, 7'h51, 2, -1, 0);
      ex_clr(); ex(C_START, 0); ex(C_ADDR, 8'hA3);
      ex(C_READ, 0); ex(C_READ, 0); ex(C_READ, 1); ex(C_STOP, 0);
      cmp("R4");
      chk(rd_n == 3, "R4", "read bytes delivered", rd_n, 3);
      if (rd_n == 3)
         for (int i = 0; i < 3; i++)
            chk(rdg[i] == 8'h62 + 8'(i), "R4", "read byte order", int'(rdg[i]), 'h62 + i);
      chk_done("R4", 0, 3, 0);
   endtask

   task automatic t_dir_change();
      run(2'b00, 1, 1, 7'h20, 0, -1, 0);
      ex_clr(); ex(C_START, 0); ex(C_ADDR, 8'h40);
      cmp("R2");
      run(2'b01, 1, 0, 7'h20, 1, -1, 0);
      ex_clr(); ex(C_START, 0); ex(C_ADDR, 8'h41); ex(C_READ, 0); ex(C_READ, 0);
      cmp("R4");
      run(2'b01, 1, 0, 7'h20, 0, -1, 0);
      ex_clr(); ex(C_READ, 0);
      cmp("R5");
   endtask

   task automatic t_abort();
      run(2'b01, 0, 1, 7'h20, 0, -1, 0);
      ex_clr(); ex(C_STOP, 0);
      cmp("R3");
      run(2'b01, 1, 0, 7'h20, 0, -1, 0);
      ex_clr(); ex(C_START, 0); ex(C_ADDR, 8'h41); ex(C_READ, 0);
      cmp("R3");
   endtask

   task automatic t_addr_nack();
      run(2'b00, 1, 0, 7'h33, 3, 1, 0);
      ex_clr(); ex(C_START, 0); ex(C_ADDR, 8'h66); ex(C_STOP, 0);
      cmp("R7");
      chk(d_nack == 1'b1, "R7", "done_nack", int'(d_nack), 1);
      chk(d_cnt == 0, "R7", "done_count", d_cnt, 0);
      run(2'b00, 1, 0, 7'h33, 0, -1, 0);
      ex_clr(); ex(C_START, 0); ex(C_ADDR, 8'h66); ex(C_WRITE, 8'h11);
      cmp("R7");
   endtask

   task automatic t_data_nack();
      run(2'b00, 1, 0, 7'h34, 4, 4, 0);
      ex_clr(); ex(C_START, 0); ex(C_ADDR, 8'h68);
      ex(C_WRITE, 8'h11); ex(C_WRITE, 8'h22); ex(C_WRITE, 8'h33); ex(C_STOP, 0);
      cmp("R8");
      chk_done("R8", 1, 2, 3);
   endtask

   task automatic t_status();
      run(2'b10, 1, 0, 7'h34, 0, -1, 0);
      ex_clr();
      cmp("R9");
      chk_done("R9", 0, 0, 3);
      run(2'b00, 1, 1, 7'h44, 0, -1, 0);
      run(2'b11, 1, 0, 7'h44, 0, -1, 0);
      ex_clr();
      cmp("R9");
      chk(d_left == 3, "R9", "held remaining count", d_left, 3);
      run(2'b00, 1, 0, 7'h44, 0, -1, 0);
      ex_clr(); ex(C_WRITE, 8'h11);
      cmp("R9");
      run(2'b10, 0, 0, 7'h44, 0, -1, 0);
      ex_clr(); ex(C_STOP, 0);
      cmp("R10");
      chk_done("R10", 0, 0, 0);
      run(2'b00, 1, 0, 7'h44, 0, -1, 0);
      ex_clr(); ex(C_START, 0); ex(C_ADDR, 8'h88); ex(C_WRITE, 8'h11);
      cmp("R10");
   endtask

   task automatic t_collide();
      run(2'b00, 0, 0, 7'h12, 1, 3, 0);
      ex_clr(); ex(C_START, 0); ex(C_ADDR, 8'h24);
      ex(C_WRITE, 8'h11); ex(C_WRITE, 8'h22); ex(C_STOP, 0);
      cmp("R8");
      chk_done("R8", 1, 1, 1);
      run(2'b10, 1, 0, 7'h12, 0, -1, 0);
      chk(d_left == 1, "R9", "remaining after last-byte NACK", d_left, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R11 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) wb[i] = 8'h11 * 8'(i + 1);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addr_open();
      t_same_write();
      t_write_close();
      t_read_new();
      t_dir_change();
      t_abort();
      t_addr_nack();
      t_data_nack();
      t_status();
      t_collide();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule